// File: doc/BRIEF.md
# Drive PIO Cycle Timing Generator

This block times one programmed-I/O access to an ATA-style drive. The access is split into three phases, each counted in bus clocks. First the address is set up. Next the read/write strobe is driven. Last comes a recovery gap. A host sequencer issues a one-clock start pulse together with a drive number from 0 to 3. The block then runs the three phases and reports completion with a one-clock done pulse.

Phase lengths come from timing fields held in a register bank outside the block. Drives 0 and 1 each have their own pair of fields. Drives 2 and 3 share a third pair. The setup length is a 2-bit code whose mapping to clocks is not linear. Active and recovery lengths are 4-bit counts in which 0 stands for 16. On later chip revisions recovery runs one clock longer than its field. An access to the drive's command-register block takes its active and recovery counts from a separate command-timing register, and its setup always uses the slowest value.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset, and whenever no access is running, addr_valid, strobe, busy and done are all 0.
- R2: The setup phase length comes from bits [7:6] of the selected address-timing byte: code 2'b00 gives 4 clocks, 2'b10 gives 3, 2'b01 gives 2 and 2'b11 gives 5.
- R3: Bits [5:0] of the address-timing byte have no effect on any phase length.
- R4: In the data-timing byte, bits [7:4] give the active count and bits [3:0] give the recovery count. A nibble of 0 means 16 clocks.
- R5: Drive 0 uses set 0 of the timing fields, drive 1 uses set 1, and drives 2 and 3 both use set 2.
- R6: When chip_rev is greater than 1, the recovery phase lasts one clock more than the decoded recovery count.
- R7: An active nibble of 1 gives an active phase of 2 clocks.
- R8: When the decoded active count is above 3 and the recovery nibble is 1, recovery is taken as 2 clocks before the revision adjustment. With an active count of 3 or less, a recovery nibble of 1 stays 1.
- R9: When cmd_block is 1, setup lasts 5 clocks and the active and recovery counts come from cmd_tim, using the same nibble rules as the data-timing byte. The drive's own fields are ignored. A cmd_tim of 0 therefore gives 5/16/16 clocks, plus the revision adjustment.
- R10: A start pulse is accepted only while busy is 0. A start during an access, including its last clock, is ignored.
- R11: The phases run in the order setup, active, recovery. addr_valid is high for all of them, strobe is high exactly during active, and done is high for one clock, the last recovery clock. busy is 0 on the following clock.
- R12: Field values are captured when the start is accepted. Changes to the inputs during an access do not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-clock request to begin an access |
| drive_idx | input | 2 | Target drive, 0 to 3 |
| cmd_block | input | 1 | Access is to the command-register block |
| chip_rev | input | 2 | Chip revision number |
| addr_tim | input | 24 | Three address-timing bytes, set s in bits [8s+7:8s] |
| data_tim | input | 24 | Three data-timing bytes, same packing |
| cmd_tim | input | 8 | Command-block timing byte (active, recovery nibbles) |
| addr_valid | output | 1 | Address held valid to the drive |
| strobe | output | 1 | Read/write strobe |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-clock pulse on the last recovery clock |

## Verification
Two situations are hard to reach from the ports: a start that lands while an access is already running, and a timing field that changes after the start has been taken. The stimulus creates both on purpose. It pulses start again in the middle of an access, using a different drive and different fields. In another access it overwrites every field one clock after acceptance and puts the old values back afterwards. The scoreboard then has to see exactly one access, with the lengths worked out from the old values. The nibble corner cases are also driven: a nibble of 0, an active nibble of 1, and a recovery nibble of 1 on either side of the active-count threshold. Each of these is combined with both revision settings.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

  localparam int FIELD_W  = 8;
  localparam int NIB_W    = 4;
  localparam int CODE_W   = 2;
  localparam int REV_W    = 2;
  // longest phase: a full nibble (16) plus one revision clock
  localparam int MAX_PHASE = (1 << NIB_W) + 1;
  localparam int CNT_W     = $clog2(MAX_PHASE + 1);

  typedef logic [CNT_W-1:0] count_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  // setup code to clock count; the mapping is not monotonic in the code
  function automatic count_t setup_clocks(input logic [CODE_W-1:0] code);
    count_t n;
    case (code)
      2'b00:   n = count_t'(4);
      2'b10:   n = count_t'(3);
      2'b01:   n = count_t'(2);
      default: n = count_t'(5);
    endcase
    return n;
  endfunction

  // a zero nibble stands for the full 16-clock count
  function automatic count_t nibble_clocks(input logic [NIB_W-1:0] nib);
    return (nib == '0) ? count_t'(1 << NIB_W) : count_t'(nib);
  endfunction

  function automatic count_t active_clocks(input logic [NIB_W-1:0] nib);
    count_t n;
    n = nibble_clocks(nib);
    if (n == count_t'(1)) n = count_t'(2);
    return n;
  endfunction

  function automatic count_t recov_clocks(input logic [NIB_W-1:0] nib,
                                          input count_t act,
                                          input logic [REV_W-1:0] rev);
    count_t n;
    n = nibble_clocks(nib);
    if (act > count_t'(3) && n == count_t'(1)) n = count_t'(2);
    if (rev > REV_W'(1)) n = n + count_t'(1);
    return n;
  endfunction

endpackage

// File: rtl/pio_field_select.sv
module pio_field_select
  import pio_timing_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int NUM_SETS   = 3
) (
  input  logic [$clog2(NUM_DRIVES)-1:0]   drive_idx,
  input  logic [NUM_SETS-1:0][FIELD_W-1:0] addr_tim,
  input  logic [NUM_SETS-1:0][FIELD_W-1:0] data_tim,
  output logic [FIELD_W-1:0]               sel_addr,
  output logic [FIELD_W-1:0]               sel_data
);
  localparam int IDX_W     = $clog2(NUM_DRIVES);
  localparam int LAST_SET  = NUM_SETS - 1;

  // each drive maps to its own set; drives at or beyond the last set share it
  logic [NUM_SETS-1:0] set_hit;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_hit
    if (s == LAST_SET) begin : g_shared
      assign set_hit[s] = (int'(drive_idx) >= s);
    end else begin : g_own
      assign set_hit[s] = (drive_idx == IDX_W'(s));
    end
  end

  always_comb begin
    sel_addr = '0;
    sel_data = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (set_hit[s]) begin
        sel_addr = sel_addr | addr_tim[s];
        sel_data = sel_data | data_tim[s];
      end
    end
  end
endmodule

// File: rtl/pio_count_calc.sv
module pio_count_calc
  import pio_timing_pkg::*;
#(
  parameter int CMD_SETUP = 5
) (
  input  logic [FIELD_W-1:0] sel_addr,
  input  logic [FIELD_W-1:0] sel_data,
  input  logic [FIELD_W-1:0] cmd_tim,
  input  logic               cmd_block,
  input  logic [REV_W-1:0]   chip_rev,
  output count_t             setup_n,
  output count_t             active_n,
  output count_t             recov_n
);
  localparam int CODE_LSB = FIELD_W - CODE_W;

  logic [FIELD_W-1:0] dt;
  logic [NIB_W-1:0]   act_nib, rec_nib;

  assign dt      = cmd_block ? cmd_tim : sel_data;
  assign act_nib = dt[FIELD_W-1 -: NIB_W];
  assign rec_nib = dt[NIB_W-1:0];

  always_comb begin
    setup_n  = cmd_block ? count_t'(CMD_SETUP)
                         : setup_clocks(sel_addr[FIELD_W-1:CODE_LSB]);
    active_n = active_clocks(act_nib);
    recov_n  = recov_clocks(rec_nib, active_n, chip_rev);
  end
endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import pio_timing_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  count_t setup_n,
  input  count_t active_n,
  input  count_t recov_n,
  output phase_e phase,
  output logic   accept,
  output logic   phase_last,
  output logic   cycle_end
);
  count_t cnt_q, act_q, rec_q;

  assign accept     = start && (phase == PH_IDLE);
  assign phase_last = (phase != PH_IDLE) && (cnt_q == '0);
  assign cycle_end  = (phase == PH_RECOV) && phase_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
      act_q <= '0;
      rec_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (accept) begin
          phase <= PH_SETUP;
          cnt_q <= setup_n - count_t'(1);
          act_q <= active_n;
          rec_q <= recov_n;
        end
        PH_SETUP: if (phase_last) begin
          phase <= PH_ACTIVE;
          cnt_q <= act_q - count_t'(1);
        end else cnt_q <= cnt_q - count_t'(1);
        PH_ACTIVE: if (phase_last) begin
          phase <= PH_RECOV;
          cnt_q <= rec_q - count_t'(1);
        end else cnt_q <= cnt_q - count_t'(1);
        default: if (phase_last) begin
          phase <= PH_IDLE;
        end else cnt_q <= cnt_q - count_t'(1);
      endcase
    end
  end
endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
  import pio_timing_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int NUM_SETS   = 3,
  parameter int CMD_SETUP  = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [$clog2(NUM_DRIVES)-1:0]     drive_idx,
  input  logic                              cmd_block,
  input  logic [1:0]                        chip_rev,
  input  logic [NUM_SETS-1:0][7:0]          addr_tim,
  input  logic [NUM_SETS-1:0][7:0]          data_tim,
  input  logic [7:0]                        cmd_tim,
  output logic                              addr_valid,
  output logic                              strobe,
  output logic                              busy,
  output logic                              done
);
  logic [FIELD_W-1:0] sel_addr, sel_data;
  count_t             setup_n, active_n, recov_n;
  phase_e             phase;
  logic               accept, phase_last, cycle_end;

  pio_field_select #(.NUM_DRIVES(NUM_DRIVES), .NUM_SETS(NUM_SETS)) u_sel (
    .drive_idx (drive_idx),
    .addr_tim  (addr_tim),
    .data_tim  (data_tim),
    .sel_addr  (sel_addr),
    .sel_data  (sel_data)
  );

  pio_count_calc #(.CMD_SETUP(CMD_SETUP)) u_calc (
    .sel_addr  (sel_addr),
    .sel_data  (sel_data),
    .cmd_tim   (cmd_tim),
    .cmd_block (cmd_block),
    .chip_rev  (chip_rev),
    .setup_n   (setup_n),
    .active_n  (active_n),
    .recov_n   (recov_n)
  );

  pio_phase_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .setup_n    (setup_n),
    .active_n   (active_n),
    .recov_n    (recov_n),
    .phase      (phase),
    .accept     (accept),
    .phase_last (phase_last),
    .cycle_end  (cycle_end)
  );

  assign addr_valid = (phase != PH_IDLE);
  assign strobe     = (phase == PH_ACTIVE);
  assign busy       = (phase != PH_IDLE);
  assign done       = cycle_end;
endmodule

// File: rtl/pio_cycle_timer_checker.sv
module pio_cycle_timer_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic accept,
  input logic phase_last,
  input logic addr_valid,
  input logic strobe,
  input logic busy,
  input logic done
);
  // an accepted start opens with setup: address valid, strobe low
  assert_setup_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (addr_valid && !strobe));

  // the strobe only rises after setup has already driven the address
  assert_strobe_after_setup_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> $past(addr_valid));

  // recovery follows the strobe: address still held when it falls
  assert_recovery_after_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> addr_valid);

  // done is single and ends the access
  assert_done_ends_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  // done only on the last clock of a phase, never during the strobe
  assert_done_at_phase_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phase_last && !strobe));

  // a start during an access that is not ending cannot stop it
  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> busy);

  // idle means every output quiet
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> (!addr_valid && !strobe && !done));
endmodule

bind pio_cycle_timer pio_cycle_timer_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .accept     (accept),
  .phase_last (phase_last),
  .addr_valid (addr_valid),
  .strobe     (strobe),
  .busy       (busy),
  .done       (done)
);

// File: tb/pio_cycle_timer_tb.sv
module pio_cycle_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      drive_idx = '0;
  logic            cmd_block = 1'b0;
  logic [1:0]      chip_rev = 2'd1;
  logic [2:0][7:0] addr_tim = '0;
  logic [2:0][7:0] data_tim = '0;
  logic [7:0]      cmd_tim = '0;
  logic            addr_valid, strobe, busy, done;

  int checks = 0;
  int errors = 0;

  typedef struct { int s; int a; int r; string tag; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_cycle_timer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .drive_idx(drive_idx),
    .cmd_block(cmd_block), .chip_rev(chip_rev), .addr_tim(addr_tim),
    .data_tim(data_tim), .cmd_tim(cmd_tim), .addr_valid(addr_valid),
    .strobe(strobe), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // expected lengths derived from the requirement text
  function automatic void expect_lens(input int idx, input bit cmd,
                                      output int s, output int a, output int r);
    int setup_tbl[4];
    int set_no, a_n, r_n;
    logic [7:0] at, dt;
    setup_tbl = '{4, 2, 3, 5};          // index = code {b7,b6}: 00,01,10,11
    set_no = (idx > 2) ? 2 : idx;
    at = addr_tim[set_no];
    dt = cmd ? cmd_tim : data_tim[set_no];
    s = cmd ? 5 : setup_tbl[{at[7], at[6]}];
    a_n = int'(dt[7:4]);
    r_n = int'(dt[3:0]);
    a = (a_n == 0) ? 16 : (a_n == 1 ? 2 : a_n);
    r = (r_n == 0) ? 16 : r_n;
    if (a >= 4 && r == 1) r = 2;
    if (chip_rev >= 2) r = r + 1;
  endfunction

  // monitor: measures each access and compares with the scoreboard
  int m_s = 0, m_a = 0, m_r = 0;
  bit prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (addr_valid) begin
        if (strobe) begin
          if (m_r != 0) check(1'b0, "R11 strobe after recovery", m_r, 0);
          m_a++;
        end else if (m_a == 0) m_s++;
        else m_r++;
      end
      if (done && prev_done) check(1'b0, "R11 done longer than one clock", 2, 1);
      if (done && !addr_valid) check(1'b0, "R11 done without addr_valid", 0, 1);
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected access", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(m_s == e.s, {e.tag, " setup"}, m_s, e.s);
          check(m_a == e.a, {e.tag, " active"}, m_a, e.a);
          check(m_r == e.r, {e.tag, " recovery"}, m_r, e.r);
        end
        m_s = 0; m_a = 0; m_r = 0;
      end
      prev_done = done;
    end
  end

  // driver: one access; mode 1 pokes start mid-access, mode 2 scrambles fields
  task automatic run_access(input int idx, input bit cmd, input string tag, input int mode);
    exp_t e;
    logic [2:0][7:0] sv_a, sv_d;
    logic [7:0] sv_c;
    logic [1:0] sv_rev;
    drive_idx = 2'(idx);
    cmd_block = cmd;
    expect_lens(idx, cmd, e.s, e.a, e.r);
    e.tag = tag;
    exp_q.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sv_a = addr_tim; sv_d = data_tim; sv_c = cmd_tim; sv_rev = chip_rev;
    if (mode == 2) begin
      addr_tim = {3{8'hC0}}; data_tim = {3{8'h99}}; cmd_tim = 8'h77; chip_rev = ~chip_rev;
      drive_idx = ~drive_idx; cmd_block = ~cmd_block;
    end
    if (mode == 1) begin
      repeat (2) @(negedge clk);
      drive_idx = 2'd1; data_tim[1] = 8'hF1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) begin
      // R10: keep start high through the last clock of the access
      if (mode == 1 && done) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    addr_tim = sv_a; data_tim = sv_d; cmd_tim = sv_c; chip_rev = sv_rev;
    check(!busy && !addr_valid && !done, {tag, " idle after done R11"}, busy, 0);
    @(negedge clk);
    check(!busy, {tag, " no restart R10"}, busy, 0);
    check(exp_q.size() == 0, {tag, " scoreboard drained"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R11 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: outputs during and after reset
    repeat (3) @(negedge clk);
    check({addr_valid, strobe, busy, done} == 4'b0, "R1 in reset", {addr_valid, strobe, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({addr_valid, strobe, busy, done} == 4'b0, "R1 after reset", {addr_valid, strobe, busy, done}, 0);

    // R2: every setup code
    chip_rev = 2'd1;
    data_tim[0] = 8'h22;
    addr_tim[0] = 8'h00; run_access(0, 0, "R2 code00", 0);
    addr_tim[0] = 8'h80; run_access(0, 0, "R2 code10", 0);
    addr_tim[0] = 8'h40; run_access(0, 0, "R2 code01", 0);
    addr_tim[0] = 8'hC0; run_access(0, 0, "R2 code11", 0);

    // R3: low address-timing bits are irrelevant
    addr_tim[0] = 8'h3F; run_access(0, 0, "R3 low bits set code00", 0);
    addr_tim[0] = 8'h95; run_access(0, 0, "R3 low bits set code10", 0);

    // R4: nibble fields and zero meaning 16
    addr_tim[1] = 8'h40;
    data_tim[1] = 8'h00; run_access(1, 0, "R4 zero nibbles", 0);
    data_tim[1] = 8'h6F; run_access(1, 0, "R4 active6 recov15", 0);

    // R5: drives 2 and 3 share set 2, set 0 unused
    addr_tim[2] = 8'h80; data_tim[2] = 8'h53; data_tim[0] = 8'hE2;
    run_access(2, 0, "R5 drive2", 0);
    run_access(3, 0, "R5 drive3", 0);

    // R6: later revision lengthens recovery
    chip_rev = 2'd2; data_tim[0] = 8'h33; addr_tim[0] = 8'h00;
    run_access(0, 0, "R6 rev2", 0);
    chip_rev = 2'd3; data_tim[0] = 8'h00;
    run_access(0, 0, "R6 rev3 zero", 0);
    chip_rev = 2'd1;

    // R7: active nibble of 1
    data_tim[0] = 8'h15; run_access(0, 0, "R7 active1", 0);

    // R8: recovery nibble of 1 around the threshold
    data_tim[0] = 8'h41; run_access(0, 0, "R8 active4 recov1", 0);
    data_tim[0] = 8'h31; run_access(0, 0, "R8 active3 recov1", 0);
    chip_rev = 2'd2;
    data_tim[0] = 8'h51; run_access(0, 0, "R8 active5 recov1 rev2", 0);
    chip_rev = 2'd1;

    // R9: command-block accesses
    cmd_tim = 8'h00; run_access(2, 1, "R9 cmd zero", 0);
    cmd_tim = 8'h23; addr_tim[0] = 8'h40; run_access(0, 1, "R9 cmd 2/3", 0);
    chip_rev = 2'd2; cmd_tim = 8'h00; run_access(1, 1, "R9 cmd zero rev2", 0);
    chip_rev = 2'd1;

    // R10: starts during an access are ignored
    data_tim[0] = 8'h44; addr_tim[0] = 8'hC0;
    run_access(0, 0, "R10 start while busy", 1);

    // R12: fields captured at start
    data_tim[2] = 8'h26; addr_tim[2] = 8'h40;
    run_access(3, 0, "R12 fields changed mid-access", 2);

    // R1: quiet while idle at the end
    repeat (3) @(negedge clk);
    check({addr_valid, strobe, busy, done} == 4'b0, "R1 idle", {addr_valid, strobe, busy, done}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule